// File: doc/BRIEF.md
# Adaptive Line Enhancer

This block pulls a weak periodic tone out of broadband noise. Each accepted input sample x[n] is compared with a prediction y[n]. An eight-tap FIR forms that prediction, and the FIR sees the input stream only through a decorrelation delay of m samples. Noise that is uncorrelated across m samples cannot be predicted. The FIR coefficients therefore settle on the periodic part of the signal. The enhanced tone comes out on `out_y`, and the residual e[n] = x[n] − y[n] comes out on `out_e`.

The coefficients adapt after every sample with a sign-data LMS rule. The error is scaled down by an arithmetic right shift, and each coefficient moves by that amount in the direction given by the sign of the sample it multiplies.

Processing is sequenced by a three-state machine:
- `ST_IDLE` waits for a sample.
- `ST_MAC` registers the FIR sum.
- `ST_EMIT` loads the outputs, adapts the coefficients and shifts the sample history.

The transitions are: `ST_IDLE`→`ST_MAC` when `in_vld` is high, `ST_MAC`→`ST_EMIT` always, and `ST_EMIT`→`ST_IDLE` always. A new sample can therefore be taken at most once every three cycles.

Top module: `ale_filter`

## Requirements
- R1: Reset clears every coefficient, the sample history, `out_vld`, `out_y` and `out_e` to zero.
- R2: A sample is taken at a rising edge where `in_vld` is high and the machine is in `ST_IDLE`. `out_vld` is then high for exactly one cycle, beginning at the second rising edge after the accepting edge, and `out_y`/`out_e` are loaded at that same edge.
- R3: `in_vld` is ignored while the machine is in `ST_MAC` or `ST_EMIT`. Such a sample produces no output pulse and changes neither the history nor the coefficients.
- R4: `out_y` = saturate16(Σ f[k]·x[n−m−k]) for k = 0..7, with m = 1 by default. Samples older than the first one after reset count as zero.
- R5: `out_e` = saturate16(x[n] − `out_y`). All samples and outputs are 16-bit two's complement.
- R6: After each output, every coefficient is updated as f[k] ← saturate16(f[k] + s·(e[n] >>> 8)), where >>> is arithmetic. s is +1 when x[n−m−k] > 0, −1 when it is < 0, and 0 when it is zero.
- R7: While all coefficients are zero, `out_y` is 0 and `out_e` equals the input sample.
- R8: `out_y` and `out_e` hold their values between output pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Sample strobe |
| in_x | input | 16 | Signed input sample x[n] |
| out_vld | output | 1 | One-cycle pulse marking new outputs |
| out_y | output | 16 | Signed prediction (enhanced periodic part) |
| out_e | output | 16 | Signed residual x[n] − y[n] |

## Verification
Both results of a sample are due at the second rising edge after the edge that accepted it. The bench drives inputs and reads outputs only at falling edges. After each accepted sample it expects `out_vld` low at the first two falling edges and high, with both values, at the third. At the fourth falling edge it expects `out_vld` low again. Each expected value comes from an integer model of R4–R6 that runs in the bench. In the ignored-strobe case, a junk sample is held on the inputs across both busy edges. Later samples then show whether that junk reached the history or the coefficients.

// File: rtl/ale_pkg.sv
package ale_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MAC  = 2'd1,
        ST_EMIT = 2'd2
    } ale_state_e;
endpackage

// File: rtl/ale_tapline.sv
module ale_tapline #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       shift_en,
    input  logic signed [W-1:0]        din,
    output logic [DEPTH-1:0][W-1:0]    hist
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (!rst_n)        hist[i] <= '0;
                else if (shift_en) hist[i] <= din;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (!rst_n)        hist[i] <= '0;
                else if (shift_en) hist[i] <= hist[i-1];
            end
        end
    end
endmodule

// File: rtl/ale_mac.sv
module ale_mac #(
    parameter int W     = 16,
    parameter int NT    = 8,
    parameter int ACC_W = 35
) (
    input  logic [NT-1:0][W-1:0]   coef,
    input  logic [NT-1:0][W-1:0]   samp,
    output logic signed [ACC_W-1:0] acc
);
    logic signed [2*W-1:0] prod [NT];

    for (genvar k = 0; k < NT; k++) begin : g_mul
        assign prod[k] = $signed(coef[k]) * $signed(samp[k]);
    end

    always_comb begin
        acc = '0;
        for (int k = 0; k < NT; k++) begin
            acc = acc + ACC_W'(prod[k]);
        end
    end
endmodule

// File: rtl/ale_coef_bank.sv
module ale_coef_bank #(
    parameter int W     = 16,
    parameter int NT    = 8,
    parameter int MU_SH = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    upd_en,
    input  logic signed [W-1:0]     err,
    input  logic [NT-1:0][W-1:0]    samp,
    output logic [NT-1:0][W-1:0]    coef
);
    localparam logic signed [W:0] CMAX = {2'b00, {(W-1){1'b1}}};
    localparam logic signed [W:0] CMIN = {2'b11, {(W-1){1'b0}}};

    logic signed [W-1:0] step;
    assign step = err >>> MU_SH;

    for (genvar k = 0; k < NT; k++) begin : g_tap
        logic signed [W:0]   wide;
        logic signed [W-1:0] nxt;
        logic signed [W:0]   cur_x;
        logic signed [W:0]   stp_x;

        assign cur_x = {coef[k][W-1], coef[k]};
        assign stp_x = {step[W-1], step};

        always_comb begin
            if ($signed(samp[k]) > 0)      wide = cur_x + stp_x;
            else if ($signed(samp[k]) < 0) wide = cur_x - stp_x;
            else                           wide = cur_x;
            if (wide > CMAX)      nxt = CMAX[W-1:0];
            else if (wide < CMIN) nxt = CMIN[W-1:0];
            else                  nxt = wide[W-1:0];
        end

        always_ff @(posedge clk) begin
            if (!rst_n)      coef[k] <= '0;
            else if (upd_en) coef[k] <= nxt;
        end
    end

    AST_COEF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable(coef)); // R6
endmodule

// File: rtl/ale_filter.sv
module ale_filter
    import ale_pkg::*;
#(
    parameter int W     = 16,
    parameter int NTAPS = 8,
    parameter int DLY   = 1,
    parameter int MU_SH = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_vld,
    input  logic signed [W-1:0] in_x,
    output logic                out_vld,
    output logic signed [W-1:0] out_y,
    output logic signed [W-1:0] out_e
);
    localparam int ACC_W = 2 * W + $clog2(NTAPS);
    localparam int DEPTH = DLY + NTAPS - 1;
    localparam logic signed [ACC_W-1:0] YMAX = ACC_W'((2 ** (W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] YMIN = -YMAX - 1;
    localparam logic signed [W:0]       EMAX = {2'b00, {(W-1){1'b1}}};
    localparam logic signed [W:0]       EMIN = {2'b11, {(W-1){1'b0}}};

    ale_state_e state_q, state_d;
    logic signed [W-1:0]     x_cur_q;
    logic signed [ACC_W-1:0] acc_q, acc_c;
    logic [DEPTH-1:0][W-1:0] hist;
    logic [NTAPS-1:0][W-1:0] win;
    logic [NTAPS-1:0][W-1:0] coef;
    logic signed [W-1:0]     y_sat, e_sat;
    logic signed [W:0]       e_wide;
    logic                    accept;

    assign accept = in_vld && (state_q == ST_IDLE);
    assign win    = hist[DLY+NTAPS-2:DLY-1];

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_vld) state_d = ST_MAC;
            ST_MAC:              state_d = ST_EMIT;
            ST_EMIT:             state_d = ST_IDLE;
            default:             state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    ale_tapline #(.W(W), .DEPTH(DEPTH)) i_tapline (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (state_q == ST_EMIT),
        .din      (x_cur_q),
        .hist     (hist)
    );

    ale_mac #(.W(W), .NT(NTAPS), .ACC_W(ACC_W)) i_mac (
        .coef (coef),
        .samp (win),
        .acc  (acc_c)
    );

    ale_coef_bank #(.W(W), .NT(NTAPS), .MU_SH(MU_SH)) i_coef (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd_en (state_q == ST_EMIT),
        .err    (e_sat),
        .samp   (win),
        .coef   (coef)
    );

    // saturation of prediction and residual
    always_comb begin
        if (acc_q > YMAX)      y_sat = YMAX[W-1:0];
        else if (acc_q < YMIN) y_sat = YMIN[W-1:0];
        else                   y_sat = acc_q[W-1:0];
        e_wide = {x_cur_q[W-1], x_cur_q} - {y_sat[W-1], y_sat};
        if (e_wide > EMAX)      e_sat = EMAX[W-1:0];
        else if (e_wide < EMIN) e_sat = EMIN[W-1:0];
        else                    e_sat = e_wide[W-1:0];
    end

    // datapath and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_cur_q <= '0;
            acc_q   <= '0;
            out_vld <= 1'b0;
            out_y   <= '0;
            out_e   <= '0;
        end else begin
            out_vld <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (in_vld) x_cur_q <= in_x;
                ST_MAC:  acc_q <= acc_c;
                ST_EMIT: begin
                    out_vld <= 1'b1;
                    out_y   <= y_sat;
                    out_e   <= e_sat;
                end
                default: ;
            endcase
        end
    end

    AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $past(accept, 3)); // R2
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |=> !out_vld); // R2
    AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && state_q != ST_IDLE) |=> (x_cur_q == $past(x_cur_q))); // R3
    AST_ERR_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && out_e != EMAX[W-1:0] && out_e != EMIN[W-1:0]) |->
        (({out_e[W-1], out_e} + {out_y[W-1], out_y}) ==
         {$past(in_x[W-1], 3), $past(in_x, 3)})); // R5
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> ($stable(out_y) && $stable(out_e))); // R8
endmodule

// File: tb/test_ale_filter.sv
module test_ale_filter;
    localparam int CLK_PERIOD = 10;
    localparam int NT  = 8;
    localparam int DL  = 1;
    localparam int WD_CYCLES = 40000;
    // stimulus x, expected y, expected e (zero coefficients, small positive inputs)
    localparam int VEC [8][3] = '{
        '{5, 0, 5}, '{0, 0, 0}, '{100, 0, 100}, '{255, 0, 255},
        '{1, 0, 1}, '{77, 0, 77}, '{200, 0, 200}, '{12, 0, 12}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_vld = 1'b0;
    logic signed [15:0] in_x = '0;
    logic out_vld;
    logic signed [15:0] out_y, out_e;

    int n_chk = 0;
    int n_bad = 0;
    int hist [NT+DL-1];
    int cf [NT];

    always #(CLK_PERIOD / 2) clk = ~clk;

    ale_filter i_ale_filter (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_x(in_x),
        .out_vld(out_vld), .out_y(out_y), .out_e(out_e)
    );

    function automatic int sat16(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NT + DL - 1; i++) hist[i] = 0;
        for (int k = 0; k < NT; k++) cf[k] = 0;
    endtask

    task automatic model_step(input int x, output int ey, output int ee);
        longint acc = 0;
        int stp, t;
        for (int k = 0; k < NT; k++) acc += longint'(cf[k]) * hist[DL-1+k];
        ey = sat16(acc);
        ee = sat16(longint'(x) - ey);
        stp = ee >>> 8;
        for (int k = 0; k < NT; k++) begin
            t = hist[DL-1+k];
            if (t > 0)      cf[k] = sat16(longint'(cf[k]) + stp);
            else if (t < 0) cf[k] = sat16(longint'(cf[k]) - stp);
        end
        for (int i = NT + DL - 2; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = x;
    endtask

    // drive one sample; optional junk strobe held over both busy edges
    task automatic send(input int x, input bit junk_on, input int junk,
                        output int gy, output int ge);
        @(negedge clk);
        chk(out_vld == 1'b0, "R2 pulse ended", int'(out_vld), 0);
        in_vld = 1'b1; in_x = 16'(x);
        @(negedge clk);
        if (junk_on) begin in_vld = 1'b1; in_x = 16'(junk); end
        else in_vld = 1'b0;
        chk(out_vld == 1'b0, "R2 early edge 1", int'(out_vld), 0);
        @(negedge clk);
        chk(out_vld == 1'b0, "R2 early edge 2", int'(out_vld), 0);
        @(negedge clk);
        in_vld = 1'b0;
        chk(out_vld == 1'b1, "R2 due edge", int'(out_vld), 1);
        gy = out_y; ge = out_e;
    endtask

    task automatic run_model(input int x, input bit junk_on, input int junk, input string tag);
        int ey, ee, gy, ge;
        model_step(x, ey, ee);
        send(x, junk_on, junk, gy, ge);
        chk(gy == ey, {tag, " R4 y"}, gy, ey);
        chk(ge == ee, {tag, " R5 e"}, ge, ee);
    endtask

    task automatic do_reset();
        in_vld = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", WD_CYCLES, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int gy, ge, ey, ee, yh, eh;
        do_reset();
        @(negedge clk);
        chk(out_vld == 1'b0, "R1 vld", int'(out_vld), 0);
        chk(out_y == 0, "R1 y", out_y, 0);
        chk(out_e == 0, "R1 e", out_e, 0);

        // table walk: R7, zero coefficients pass the input to the residual
        foreach (VEC[i]) begin
            model_step(VEC[i][0], ey, ee);
            send(VEC[i][0], 1'b0, 0, gy, ge);
            chk(gy == VEC[i][1], "R7 y", gy, VEC[i][1]);
            chk(ge == VEC[i][2], "R7 e", ge, VEC[i][2]);
        end

        // periodic tone in noise: adaptation, R4 R5 R6
        for (int i = 0; i < 300; i++) begin
            int tone, noise;
            case (i % 4)
                0: tone = 12000;
                2: tone = -12000;
                default: tone = 0;
            endcase
            noise = ((i * 7919) % 2001) - 1000;
            run_model(tone + noise, 1'b0, 0, "R6 tone");
        end

        // R8: outputs hold between pulses
        yh = out_y; eh = out_e;
        repeat (3) @(negedge clk);
        chk(out_y == yh, "R8 y hold", out_y, yh);
        chk(out_e == eh, "R8 e hold", out_e, eh);

        // R3: junk strobe during busy cycles must leave no trace
        run_model(9000, 1'b1, -31000, "R3 busy");
        @(negedge clk);
        chk(out_vld == 1'b0, "R3 no extra pulse", int'(out_vld), 0);
        for (int i = 0; i < 8; i++) run_model((i % 2) ? -15000 : 15000, 1'b0, 0, "R3 after");

        // extremes for saturation paths (R5, R6)
        for (int i = 0; i < 40; i++) run_model((i % 2) ? -32768 : 32767, 1'b0, 0, "R5 extreme");

        // R1: reset clears coefficients and history
        do_reset();
        @(negedge clk);
        chk(out_y == 0, "R1 y after reset", out_y, 0);
        run_model(20000, 1'b0, 0, "R1 first");
        send(-3000, 1'b0, 0, gy, ge);
        chk(gy == 0, "R1 coef cleared y", gy, 0);
        chk(ge == -3000, "R1 coef cleared e", ge, -3000);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule